// File: doc/BRIEF.md
# Ready-Stream Issue Selector

This block picks, on every clock cycle, one hardware instruction stream out of a large pool of contexts to issue from. It walks the streams in a rotating order that starts just past the stream it served last. It passes over any stream that is not present, not ready, or stalled on memory. Because it may change streams every cycle, a pipeline fed by it can hide long latencies by interleaving many streams.

Each memory instruction a stream issues carries a lookahead value. The value says how many further memory operations the stream may start before it must wait for earlier ones. The selector keeps two numbers for every stream: the memory operations still in flight and the budget left under the current lookahead window. A stream with operations in flight and no budget left is stalled. Tagged completion pulses return operations. When a stream's last operation comes back, it is free again. The selection is combinational from registered state and the present valid/ready flags. Issue and completion events take effect on the next clock edge.

Top module: `stream_picker`

## Requirements
- R1: A synchronous active-high reset clears every in-flight count and sets the rotation start to stream 0, so the first grant after reset goes to the lowest eligible stream.
- R2: A stream is granted only if its valid and ready flags are both high and it is not stalled. When no stream qualifies, sel_vld is low and the rotation start keeps its value.
- R3: The grant goes to the first eligible stream at or after the rotation start, wrapping past the highest index to 0. After a grant the rotation start becomes the granted index plus one, modulo the stream count.
- R4: An accepted issue on a stream with nothing in flight sets its count to 1 and its budget to the issued lookahead. A lookahead of 0 stalls the stream at once.
- R5: An accepted issue on a stream that already has operations in flight increments the count. It sets the budget to the smaller of (old budget minus one) and the new lookahead.
- R6: A completion pulse tagged with a stream decrements that stream's count. The stream stays stalled while the count is above zero and the budget is zero. It is free again once the count reaches zero.
- R7: A completion for a stream whose count is already zero is ignored; the count stays at zero.
- R8: An issue event for a stream that is stalled is ignored and does not raise its count.
- R9: An accepted issue and a completion for the same stream in the same cycle leave the count unchanged. The budget still follows R5.
- R10: A stream's in-flight count never exceeds 2 to the power of the lookahead width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strm_valid | input | N_STREAMS | Stream holds a live context |
| strm_ready | input | N_STREAMS | Stream has an instruction ready apart from memory stalls |
| iss_vld | input | 1 | A memory instruction issues this cycle |
| iss_id | input | clog2(N_STREAMS) | Stream that issued the memory instruction |
| iss_la | input | LA_W | Lookahead value carried by that instruction |
| cmp_vld | input | 1 | A memory operation completes this cycle |
| cmp_id | input | clog2(N_STREAMS) | Stream the completion belongs to |
| sel_vld | output | 1 | A stream is selected this cycle |
| sel_id | output | clog2(N_STREAMS) | Selected stream index |

## Verification
The hardest situation to reach from the ports is a stream that is stalled with several operations still in flight. Whether it stays stalled or frees up then depends on the exact count, and the count cannot be read out. The stimulus builds that state with chains of issues whose lookahead values shrink the budget. It then returns completions one by one and watches the grant at each step, with only the stream under test present. Ignored issues, completions at a zero count and same-cycle issue/completion pairs are placed in those chains. Each of them is judged by the number of completions needed before the stream is granted again.

// File: rtl/sp_pkg.sv
package sp_pkg;
   localparam int DEF_STREAMS = 128;
   localparam int DEF_LA_W    = 4;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sp_slot.sv
module sp_slot #(
   parameter int LA_W = sp_pkg::DEF_LA_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid,
   input  logic            ready,
   input  logic            iss_hit,
   input  logic [LA_W-1:0] iss_la,
   input  logic            cmp_hit,
   output logic            elig
);
   localparam int CW = LA_W + 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(1) << LA_W;

   logic [CW-1:0]   cnt_q, cnt_d;
   logic [LA_W-1:0] bud_q, bud_d, bud_m1;
   logic            stalled, take, drop;

   assign stalled = (cnt_q != '0) && (bud_q == '0);
   assign take    = iss_hit && !stalled;
   assign drop    = cmp_hit && (cnt_q != '0);
   assign elig    = valid && ready && !stalled;
   assign bud_m1  = bud_q - 1'b1;

   always_comb begin
      cnt_d = cnt_q;
      bud_d = bud_q;
      if (take) begin
         if (cnt_q == '0)          bud_d = iss_la;
         else if (bud_m1 < iss_la) bud_d = bud_m1;
         else                      bud_d = iss_la;
      end
      if (take && !drop) begin
         cnt_d = cnt_q + 1'b1;
      end else if (!take && drop) begin
         cnt_d = cnt_q - 1'b1;
         if (cnt_q == CW'(1)) bud_d = '1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         bud_q <= '1;
      end else begin
         cnt_q <= cnt_d;
         bud_q <= bud_d;
      end
   end

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_MAX);
   assert_cmp_decrements_R6: assert property (@(posedge clk) disable iff (rst)
      (cmp_hit && !iss_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   assert_zero_cmp_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (cmp_hit && !iss_hit && cnt_q == '0) |=> (cnt_q == '0));
   assert_stalled_issue_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (iss_hit && !cmp_hit && stalled) |=> $stable(cnt_q));
endmodule

// File: rtl/sp_rotor.sv
module sp_rotor #(
   parameter int N   = sp_pkg::DEF_STREAMS,
   parameter int IDW = sp_pkg::idx_w(N)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N-1:0]   elig,
   output logic           gnt_vld,
   output logic [IDW-1:0] gnt_id
);
   logic [IDW-1:0] ptr_q;
   logic           hit_hi, hit_any;
   logic [IDW-1:0] idx_hi, idx_any;

   always_comb begin
      hit_hi  = 1'b0;
      hit_any = 1'b0;
      idx_hi  = '0;
      idx_any = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i]) begin
            hit_any = 1'b1;
            idx_any = IDW'(i);
            if (i >= int'(ptr_q)) begin
               hit_hi = 1'b1;
               idx_hi = IDW'(i);
            end
         end
      end
   end

   assign gnt_vld = hit_any;
   assign gnt_id  = hit_hi ? idx_hi : idx_any;

   always_ff @(posedge clk) begin
      if (rst)          ptr_q <= '0;
      else if (gnt_vld) ptr_q <= (gnt_id == IDW'(N - 1)) ? '0 : gnt_id + 1'b1;
   end

   assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (rst)
      gnt_vld |-> elig[gnt_id]);
   assert_idle_holds_ptr_R2: assert property (@(posedge clk) disable iff (rst)
      !gnt_vld |=> (ptr_q == $past(ptr_q)));
   assert_ptr_follows_grant_R3: assert property (@(posedge clk) disable iff (rst)
      (gnt_vld && gnt_id != IDW'(N - 1)) |=> (ptr_q == $past(gnt_id) + 1'b1));
   assert_ptr_wraps_R3: assert property (@(posedge clk) disable iff (rst)
      (gnt_vld && gnt_id == IDW'(N - 1)) |=> (ptr_q == '0));
endmodule

// File: rtl/stream_picker.sv
module stream_picker #(
   parameter int N_STREAMS = sp_pkg::DEF_STREAMS,
   parameter int LA_W      = sp_pkg::DEF_LA_W,
   localparam int IDW      = sp_pkg::idx_w(N_STREAMS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [N_STREAMS-1:0] strm_valid,
   input  logic [N_STREAMS-1:0] strm_ready,
   input  logic                 iss_vld,
   input  logic [IDW-1:0]       iss_id,
   input  logic [LA_W-1:0]      iss_la,
   input  logic                 cmp_vld,
   input  logic [IDW-1:0]       cmp_id,
   output logic                 sel_vld,
   output logic [IDW-1:0]       sel_id
);
   if (N_STREAMS < 2) begin : g_bad_n
      $error("stream_picker: N_STREAMS must be at least 2");
   end
   if (LA_W < 1 || LA_W > 8) begin : g_bad_la
      $error("stream_picker: LA_W must lie in 1..8");
   end

   logic [N_STREAMS-1:0] elig;

   for (genvar g = 0; g < N_STREAMS; g++) begin : g_slot
      sp_slot #(.LA_W(LA_W)) u_slot (
         .clk     (clk),
         .rst     (rst),
         .valid   (strm_valid[g]),
         .ready   (strm_ready[g]),
         .iss_hit (iss_vld && (iss_id == IDW'(g))),
         .iss_la  (iss_la),
         .cmp_hit (cmp_vld && (cmp_id == IDW'(g))),
         .elig    (elig[g])
      );
   end

   sp_rotor #(.N(N_STREAMS), .IDW(IDW)) u_rotor (
      .clk     (clk),
      .rst     (rst),
      .elig    (elig),
      .gnt_vld (sel_vld),
      .gnt_id  (sel_id)
   );
endmodule

// File: tb/tb_stream_picker.sv
`timescale 1ns/1ps
module tb_stream_picker;
   localparam int N   = 8;
   localparam int LW  = 3;
   localparam int IDW = 3;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [N-1:0]   strm_valid = '0;
   logic [N-1:0]   strm_ready = '0;
   logic           iss_vld = 1'b0;
   logic [IDW-1:0] iss_id = '0;
   logic [LW-1:0]  iss_la = '0;
   logic           cmp_vld = 1'b0;
   logic [IDW-1:0] cmp_id = '0;
   logic           sel_vld;
   logic [IDW-1:0] sel_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   stream_picker #(.N_STREAMS(N), .LA_W(LW)) dut (
      .clk(clk), .rst(rst), .strm_valid(strm_valid), .strm_ready(strm_ready),
      .iss_vld(iss_vld), .iss_id(iss_id), .iss_la(iss_la),
      .cmp_vld(cmp_vld), .cmp_id(cmp_id), .sel_vld(sel_vld), .sel_id(sel_id)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic look(input bit ev, input int eid, input string req);
      #1;
      n_chk++;
      if (sel_vld !== ev || (ev && sel_id !== IDW'(eid))) begin
         n_bad++;
         $display("FAIL %s: vld/id = %0b/%0d, expected %0b/%0d", req, sel_vld, sel_id, ev, eid);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; iss_vld = 1'b0; cmp_vld = 1'b0;
      strm_valid = '0; strm_ready = '0;
      tick(); tick();
      rst = 1'b0;
   endtask

   task automatic only(input int s);
      strm_valid = '0; strm_ready = '0;
      strm_valid[s] = 1'b1; strm_ready[s] = 1'b1;
   endtask

   task automatic issue(input int s, input int la);
      iss_vld = 1'b1; iss_id = IDW'(s); iss_la = LW'(la);
      tick();
      iss_vld = 1'b0;
   endtask

   task automatic complete(input int s);
      cmp_vld = 1'b1; cmp_id = IDW'(s);
      tick();
      cmp_vld = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      strm_valid = '1; strm_ready = '1;
      look(1, 0, "R1 first grant after reset");
   endtask

   task automatic t_rotate();
      do_reset();
      strm_valid = '1; strm_ready = '1;
      for (int k = 0; k < 9; k++) begin
         look(1, k % N, "R3 full rotation");
         tick();
      end
   endtask

   task automatic t_skip();
      do_reset();
      strm_valid = 8'b1010_0100; strm_ready = '1;
      look(1, 2, "R2 skip absent"); tick();
      look(1, 5, "R2 skip absent"); tick();
      look(1, 7, "R2 skip absent"); tick();
      look(1, 2, "R3 wrap to lowest"); tick();
      strm_valid = '1; strm_ready = 8'b0000_1000;
      look(1, 3, "R2 ready gate"); tick();
      look(1, 3, "R2 ready gate again");
      do_reset();
      strm_valid = 8'b1000_0001; strm_ready = '1;
      look(1, 0, "R3 pair low"); tick();
      look(1, 7, "R3 pair high"); tick();
      look(1, 0, "R3 wrap after top"); tick();
   endtask

   task automatic t_idle();
      do_reset();
      only(3);
      look(1, 3, "R3 lone grant"); tick();
      strm_valid = '0;
      look(0, 0, "R2 nothing eligible"); tick();
      tick();
      strm_valid = '1; strm_ready = '1;
      look(1, 4, "R2 pointer held while idle");
   endtask

   task automatic t_la_zero();
      do_reset();
      only(1);
      look(1, 1, "R4 eligible before issue");
      issue(1, 0);
      look(0, 0, "R4 lookahead 0 stalls");
      complete(1);
      look(1, 1, "R6 free at zero count");
   endtask

   task automatic t_chain();
      do_reset();
      only(2);
      issue(2, 2);
      look(1, 2, "R4 budget 2 after first issue");
      issue(2, 7);
      look(1, 2, "R5 budget 1 after second issue");
      issue(2, 7);
      look(0, 0, "R5 budget spent after third issue");
      complete(2);
      look(0, 0, "R6 still stalled with 2 in flight");
      issue(2, 7);
      look(0, 0, "R8 issue while stalled");
      complete(2);
      look(0, 0, "R8 one left in flight");
      complete(2);
      look(1, 2, "R8 ignored issue needed no completion");
   endtask

   task automatic t_shrink();
      do_reset();
      only(6);
      issue(6, 3);
      look(1, 6, "R4 budget 3");
      issue(6, 0);
      look(0, 0, "R5 smaller lookahead wins");
      complete(6);
      look(0, 0, "R6 one in flight");
      complete(6);
      look(1, 6, "R6 cleared");
   endtask

   task automatic t_zero_cmp();
      do_reset();
      only(4);
      complete(4);
      look(1, 4, "R7 stray completion");
      issue(4, 0);
      look(0, 0, "R7 stalled");
      complete(4);
      look(1, 4, "R7 count stayed at zero");
   endtask

   task automatic t_same_cycle();
      do_reset();
      only(5);
      issue(5, 1);
      look(1, 5, "R9 budget 1");
      iss_vld = 1'b1; iss_id = 3'd5; iss_la = 3'd1;
      cmp_vld = 1'b1; cmp_id = 3'd5;
      tick();
      iss_vld = 1'b0; cmp_vld = 1'b0;
      look(0, 0, "R9 budget spent, count kept");
      complete(5);
      look(1, 5, "R9 one completion frees");
   endtask

   task automatic t_deep();
      do_reset();
      only(0);
      for (int k = 0; k < 8; k++) issue(0, 7);
      look(0, 0, "R10 stalled at full depth");
      for (int k = 0; k < 7; k++) complete(0);
      look(0, 0, "R10 one of eight still out");
      complete(0);
      look(1, 0, "R10 all eight returned");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual running, expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_rotate();
      t_skip();
      t_idle();
      t_la_zero();
      t_chain();
      t_shrink();
      t_zero_cmp();
      t_same_cycle();
      t_deep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule